// File: doc/BRIEF.md
# I2C Register Target

This block is a two-wire bus target that gives an external controller access to a bank of 8-bit control registers. The bank lives outside the block. The controller first sends a one-byte register index, called the pointer, and then moves one or more data bytes. Each byte written arrives at the register side as a one-cycle write strobe carrying the pointer and the byte. Each byte read is fetched through a combinational read port addressed by the pointer. After every data byte the pointer advances by one, so a burst walks through consecutive registers.

Both bus lines are brought into the system clock domain through multi-flop synchronizers. START and STOP are recognised from the synchronized lines. SDA is driven open-drain: the block only raises an enable that pulls the line low. The low bit of the 7-bit target address comes from a strap pin. The pin is sampled once, when reset is released, so two such targets can share one bus.

A read is done with the combined format. The controller writes the pointer, issues a repeated START and then reads with the read address. Alternatively it reads directly, continuing from the pointer left by an earlier transfer.

Top module: `i2c_reg_target`

## Requirements
- R1: The target answers to the 7-bit address 1011_10x, where x is the latched strap bit. Address bytes B8h/B9h (strap 0) or BAh/BBh (strap 1) are acknowledged by pulling SDA low in the ninth clock.
- R2: The strap bit is taken from `addr_sel` at the first clock edge after `rst_n` goes high. Later changes of `addr_sel` have no effect until the next reset.
- R3: In a write, the byte after the address (R/W bit 0) sets the pointer. Each following byte is acknowledged and produces exactly one cycle of `reg_wr_en`, with `reg_wr_addr` equal to the pointer and `reg_wr_data` equal to the byte, sent MSB first.
- R4: The pointer is 8 bits wide. It increments by one after every data byte, read or written, and wraps from FFh to 00h. Its value is visible on `reg_rd_addr`.
- R5: After an address byte with R/W bit 1 is acknowledged, the target sends `reg_rd_data` for the current pointer, MSB first. It sends one byte per controller ACK.
- R6: When the controller answers a read byte with NAK (SDA high in the ninth clock), the target releases SDA. It stays silent until the next START.
- R7: An address byte that does not match is not acknowledged. SDA stays released and no register write occurs until the next START.
- R8: A START (SDA falling while SCL high) or a STOP (SDA rising while SCL high) aborts any byte in progress without a write. A START leads to address reception; both keep the pointer value.
- R9: `sda_oe` (1 = pull SDA low) changes only while synchronized SCL is low, except when released by START or STOP.
- R10: During and right after reset, `sda_oe` and `reg_wr_en` are 0 and `reg_rd_addr` is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 1 | Strap that selects the address LSB |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Register index of the write |
| reg_wr_data | output | 8 | Data of the write |
| reg_rd_addr | output | 8 | Current pointer, used as read index |
| reg_rd_data | input | 8 | Register contents at `reg_rd_addr` |

## Verification
On every cycle, the assertions check several properties:
- the data-line enable moves only while the synchronized clock is low, or when a START or STOP releases it;
- a write strobe appears only at a data-byte acknowledge;
- a START or STOP lands the state machine in address reception or idle, with SDA released;
- the target stays silent while skipping or idle;
- the bit counter stays within a byte;
- the latched strap bit never moves after capture.

Only the bench's scenarios can show the rest: address matching under both strap values, pointer wrap across FFh, the contents of read bursts, the effect of a NAK, and pointer retention across STOP and START.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] ptr;
        logic              rw;
        logic              oe;
        logic              mack;
        logic              wr_en;
        logic [BYTE_W-1:0] wr_addr;
        logic [BYTE_W-1:0] wr_data;
    } tgt_regs_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], line_i};
        prev_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    assign start_o = scl_lvl & sda_fall;
    assign stop_o  = scl_lvl & sda_rise;
endmodule

// File: rtl/i2c_strap_latch.sv
module i2c_strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic bit_o
);
    logic seen_d, seen_q;
    logic bit_d, bit_q;

    always_comb begin
        seen_d = 1'b1;
        bit_d  = seen_q ? bit_q : pin_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            bit_q  <= 1'b0;
        end else begin
            seen_q <= seen_d;
            bit_q  <= bit_d;
        end
    end

    assign bit_o = bit_q;

    // R2: once captured, the strap bit never moves
    p_strap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(seen_q)) |-> $stable(bit_q));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_regif_pkg::*;
#(
    parameter int             SYNC_STAGES = 2,
    parameter logic [5:0]     ADDR_HI     = 6'b101110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              addr_sel,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wr_addr,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic [BYTE_W-1:0] reg_rd_addr,
    input  logic [BYTE_W-1:0] reg_rd_data
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic [1:0] lvl, rise, fall;
    logic       start_det, stop_det, a0;
    logic [1:0] line_in;

    assign line_in = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk(clk), .rst_n(rst_n), .line_i(line_in[g]),
            .level_o(lvl[g]), .rise_o(rise[g]), .fall_o(fall[g])
        );
    end

    logic scl_s, sda_s, scl_rise, scl_fall;
    assign scl_s    = lvl[0];
    assign sda_s    = lvl[1];
    assign scl_rise = rise[0];
    assign scl_fall = fall[0];

    i2c_bus_cond i_cond (
        .scl_lvl(scl_s), .sda_rise(rise[1]), .sda_fall(fall[1]),
        .start_o(start_det), .stop_o(stop_det)
    );

    i2c_strap_latch i_strap (
        .clk(clk), .rst_n(rst_n), .pin_i(addr_sel), .bit_o(a0)
    );

    tgt_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        if (start_det) begin
            r_d.state = ST_ADDR;
            r_d.cnt   = '0;
            r_d.oe    = 1'b0;
        end else if (stop_det) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
            r_d.oe    = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (scl_rise && r_q.cnt < FULL) begin
                        r_d.shreg = {r_q.shreg[BYTE_W-2:0], sda_s};
                        r_d.cnt   = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == FULL) begin
                        r_d.cnt = '0;
                        if (r_q.state == ST_ADDR) begin
                            if (r_q.shreg[BYTE_W-1:1] == {ADDR_HI, a0}) begin
                                r_d.rw    = r_q.shreg[0];
                                r_d.oe    = 1'b1;
                                r_d.state = ST_ADDR_ACK;
                            end else begin
                                r_d.state = ST_SKIP;
                            end
                        end else if (r_q.state == ST_SUB) begin
                            r_d.ptr   = r_q.shreg;
                            r_d.oe    = 1'b1;
                            r_d.state = ST_SUB_ACK;
                        end else begin
                            r_d.wr_en   = 1'b1;
                            r_d.wr_addr = r_q.ptr;
                            r_d.wr_data = r_q.shreg;
                            r_d.ptr     = r_q.ptr + 1'b1;
                            r_d.oe      = 1'b1;
                            r_d.state   = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        r_d.oe = 1'b0;
                        if (r_q.state == ST_ADDR_ACK && r_q.rw) begin
                            r_d.shreg = reg_rd_data;
                            r_d.oe    = ~reg_rd_data[BYTE_W-1];
                            r_d.state = ST_RDATA;
                        end else if (r_q.state == ST_ADDR_ACK) begin
                            r_d.state = ST_SUB;
                        end else begin
                            r_d.state = ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && r_q.cnt < FULL) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == FULL) begin
                            r_d.oe    = 1'b0;
                            r_d.ptr   = r_q.ptr + 1'b1;
                            r_d.cnt   = '0;
                            r_d.state = ST_RDATA_ACK;
                        end else begin
                            r_d.shreg = {r_q.shreg[BYTE_W-2:0], 1'b0};
                            r_d.oe    = ~r_q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.shreg = reg_rd_data;
                            r_d.oe    = ~reg_rd_data[BYTE_W-1];
                            r_d.state = ST_RDATA;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe      = r_q.oe;
    assign reg_wr_en   = r_q.wr_en;
    assign reg_wr_addr = r_q.wr_addr;
    assign reg_wr_data = r_q.wr_data;
    assign reg_rd_addr = r_q.ptr;

    // R9: drive changes only while SCL is low, or on abort
    p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_d.oe != r_q.oe) |-> (!scl_s || start_det || stop_det));
    // R3: write strobe only together with the data acknowledge
    p_wr_at_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (r_q.state == ST_WDATA_ACK && sda_oe));
    // R8: START leads to address reception with SDA released
    p_start_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (r_q.state == ST_ADDR && !sda_oe && !reg_wr_en));
    // R8: STOP returns to idle
    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (r_q.state == ST_IDLE && !sda_oe));
    // R7: a non-matching target stays silent
    p_skip_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SKIP) |-> (!sda_oe && !reg_wr_en));
    // R6: idle after NAK never drives
    p_idle_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> !sda_oe);
    // R3: bit counter stays within one byte
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= FULL);
endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b0;
    logic       sda_oe, reg_wr_en;
    logic [7:0] reg_wr_addr, reg_wr_data, reg_rd_addr, reg_rd_data;
    logic       sda_line;

    logic [7:0] mem [256];
    logic [7:0] model [256];
    int         wr_cnt = 0;
    int         oe_viol = 0;
    logic       prev_oe = 1'b0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    logic [7:0] wbuf [4];
    logic [7:0] rbuf [4];

    always #4 clk = ~clk;

    assign sda_line    = sda_m & ~sda_oe;
    assign reg_rd_data = mem[reg_rd_addr];

    i2c_reg_target i_i2c_reg_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_sel(addr_sel),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
        end else if (reg_wr_en) begin
            mem[reg_wr_addr] <= reg_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (rst_n && sda_oe != prev_oe && scl) oe_viol <= oe_viol + 1;
        prev_oe <= sda_oe;
    end

    function automatic logic [7:0] addr_byte(input logic a0, input logic rd);
        return {6'b101110, a0, rd};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; addr_sel = strap;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        wt(4);
        check(sda_oe == 1'b0 && reg_wr_en == 1'b0 && reg_rd_addr == 8'h00,
              "R10", {sda_oe, reg_wr_en, reg_rd_addr}, 0);
        rst_n = 1'b1;
        wt(3);
        addr_sel = ~strap;
        wt(2);
        check(sda_oe == 1'b0 && reg_rd_addr == 8'h00, "R10", reg_rd_addr, 0);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wt(H); scl = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl = 1'b0; wt(H);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wt(H); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wt(H); scl = 1'b1; wt(H); scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wt(H); scl = 1'b1; wt(H / 2); b = sda_line; wt(H / 2); scl = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    task automatic write_burst(input logic a0, input logic [7:0] sub, input int n);
        logic ack;
        int   w0;
        w0 = wr_cnt;
        i2c_start();
        put_byte(addr_byte(a0, 1'b0), ack);
        check(ack, "R1 write address ack", ack, 1);
        put_byte(sub, ack);
        check(ack, "R3 subaddress ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i], ack);
            check(ack, "R3 data ack", ack, 1);
            model[8'(sub + i)] = wbuf[i];
        end
        i2c_stop();
        check(wr_cnt - w0 == n, "R3 strobe count", wr_cnt - w0, n);
        check(reg_rd_addr == 8'(sub + n), "R4 pointer after write", reg_rd_addr, 8'(sub + n));
    endtask

    task automatic read_burst(input logic a0, input logic [7:0] sub, input int n);
        logic ack;
        i2c_start();
        put_byte(addr_byte(a0, 1'b0), ack);
        check(ack, "R1 address ack", ack, 1);
        put_byte(sub, ack);
        check(ack, "R5 subaddress ack", ack, 1);
        i2c_start();
        put_byte(addr_byte(a0, 1'b1), ack);
        check(ack, "R5 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            get_byte(rbuf[i], i != n - 1);
            check(rbuf[i] == model[8'(sub + i)], "R5 read data",
                  rbuf[i], model[8'(sub + i)]);
        end
        i2c_stop();
        check(reg_rd_addr == 8'(sub + n), "R4 pointer after read", reg_rd_addr, 8'(sub + n));
    endtask

    initial begin
        logic       ack, b;
        logic [7:0] v;
        int         w0, n;
        logic [7:0] sub;
        void'($urandom(32'h5eed_1234));

        // R10 and R2: strap 0 latched, pin then flipped
        do_reset(1'b0);
        i2c_start();
        put_byte(8'hB8, ack);
        check(ack, "R1 B8 acked with strap 0", ack, 1);
        i2c_stop();
        w0 = wr_cnt;
        i2c_start();
        put_byte(8'hBA, ack);
        check(!ack, "R2 later pin change ignored, BA not acked", ack, 0);
        put_byte(8'h20, ack);
        check(!ack && !sda_oe, "R7 no ack after mismatch", ack, 0);
        put_byte(8'h55, ack);
        i2c_stop();
        check(wr_cnt == w0, "R7 no write after mismatch", wr_cnt - w0, 0);

        // R4: wrap across FFh
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        write_burst(1'b0, 8'hFE, 3);
        check(mem[8'h00] == 8'hC3, "R4 wrap write landed at 00h", mem[8'h00], 8'hC3);
        read_burst(1'b0, 8'hFE, 3);

        // R6: after NAK the target stays silent
        i2c_start();
        put_byte(8'hB8, ack);
        put_byte(8'h00, ack);
        i2c_start();
        put_byte(8'hB9, ack);
        get_byte(v, 1'b0);
        check(v == model[8'h00], "R5 single read", v, model[8'h00]);
        v = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        check(v == 8'hFF, "R6 bus released after NAK", v, 8'hFF);
        i2c_stop();

        // R8: pointer retained across STOP/START, direct read
        wbuf[0] = 8'h3C;
        write_burst(1'b0, 8'h40, 1);
        mem_seed: begin
            wbuf[0] = 8'h77;
            write_burst(1'b0, 8'h41, 1);
        end
        i2c_start();
        put_byte(8'hB8, ack);
        put_byte(8'h41, ack);
        i2c_stop();
        check(reg_rd_addr == 8'h41, "R8 pointer kept across STOP", reg_rd_addr, 8'h41);
        i2c_start();
        put_byte(8'hB9, ack);
        check(ack, "R8 direct read ack", ack, 1);
        get_byte(v, 1'b0);
        i2c_stop();
        check(v == 8'h77, "R8 direct read from kept pointer", v, 8'h77);

        // R8: STOP in the middle of a data byte aborts without write
        w0 = wr_cnt;
        i2c_start();
        put_byte(8'hB8, ack);
        put_byte(8'h10, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        i2c_stop();
        check(wr_cnt == w0, "R8 abort without write", wr_cnt - w0, 0);
        check(reg_rd_addr == 8'h10, "R8 pointer after abort", reg_rd_addr, 8'h10);

        // R2: strap 1 after a new reset
        do_reset(1'b1);
        i2c_start();
        put_byte(8'hBA, ack);
        check(ack, "R2 BA acked with strap 1", ack, 1);
        i2c_stop();
        i2c_start();
        put_byte(8'hB8, ack);
        check(!ack, "R2 B8 not acked with strap 1", ack, 0);
        i2c_stop();

        // R3/R4/R5: random bursts
        for (int it = 0; it < 12; it++) begin
            sub = 8'($urandom);
            if (it == 0) sub = 8'hFD;
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
            write_burst(1'b1, sub, n);
            read_burst(1'b1, sub, n);
        end

        check(oe_viol == 0, "R9 drive changed with SCL high", oe_viol, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule